// File: doc/BRIEF.md
# Time-Multiplexed Word Switchbox

This block is one routing node in a coarse-grained array. Four word-wide buses arrive at it, one from each side (north, east, south, west). Each side has one outgoing bus. Every outgoing bus is picked from the three buses arriving on the other sides, and is never looped back to its own side. The choice is not fixed. A phase counter steps through a small configuration store once per clock, so each route can change every cycle in step with a compile-time schedule. Every result passes through a register before it leaves for the next hop.

The schedule length is set by a last-phase value, which is the initiation interval minus one, for initiation intervals of 1 to 16. The routing entries and the last-phase value are loaded while the block is held in reset. A stall input freezes the node. The phase does not advance, and a built-in all-hold entry replaces the scheduled one, so every output register keeps its word. When stall drops, the schedule continues from the phase where it stopped.

The block has no valid/ready signals and applies no back-pressure. Data moves on a fixed schedule, so the only way to pause it is the stall pin, and all four outputs pause together.

Top module: `tmux_switchbox`

## Requirements
- R1: While rst_n is low, all four outputs read zero and cur_phase reads zero.
- R2: An entry holds one 3-bit route field per output side. The field for side d sits at bits [3d+2:3d], with sides numbered north 0, east 1, south 2, west 3. Bit 2 of the field is the enable and bits 1:0 are a rotation r. When the entry is enabled and r is 0, 1 or 2, output d takes input (d+1+r) mod 4, so an output never takes its own side's input.
- R3: Outputs are registered. A change on bus_in shows on bus_out only after the next rising clock edge, and never before it.
- R4: While not stalled, cur_phase advances by one each clock and returns to 0 on the edge after it equals the loaded last-phase value. Last-phase values 0 to 15 are supported.
- R5: While stall is high at a clock edge, cur_phase and all four outputs keep their values, whatever bus_in does.
- R6: After stall falls, routing resumes with the entry of the phase at which it stopped. No phase is skipped and none is repeated.
- R7: When an output's route field has its enable clear, or has rotation 3, that output keeps its value for that phase.
- R8: cfg_we/cfg_addr/cfg_wdata writes and the ii_last value are taken only on clock edges where rst_n is low. At other times they have no effect on routing or on the schedule length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration load window |
| stall | input | 1 | Freezes the phase and holds all output registers |
| ii_last | input | PW (4) | Last phase index (initiation interval minus 1), captured during reset |
| cfg_we | input | 1 | Configuration write strobe, taken only during reset |
| cfg_addr | input | PW (4) | Phase index of the entry to write |
| cfg_wdata | input | 12 | Route entry: four 3-bit fields, one per output side |
| bus_in | input | 4*W (64) | Incoming words; side d at [d*W +: W] |
| bus_out | output | 4*W (64) | Registered outgoing words; side d at [d*W +: W] |
| cur_phase | output | PW (4) | Current schedule phase |

## Verification
The bench targets these corner cases:
- An initiation interval of 1. A counter that mishandles a last-phase value of zero would walk into unloaded entries.
- The full 16-phase schedule, where an off-by-one wrap would skip or repeat a phase.
- A stall in mid-schedule while the inputs keep changing. A design that only gates the counter would let new words through the output registers, and one that steps on release would resume on the wrong entry.
- Disabled fields and rotation 3 must hold the output rather than pass some input.
- Writes and last-phase changes outside reset must leave the running schedule untouched.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int NDIR    = 4;
  localparam int ROUTE_W = 3;
  localparam int ENTRY_W = NDIR * ROUTE_W;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  typedef struct packed {
    logic       en;
    logic [1:0] rot;
  } route_t;

  // Entry applied while stalled: every output holds.
  localparam logic [ENTRY_W-1:0] HOLD_ENTRY = '0;

  // Source side for an output: skip own side, then rotate.
  function automatic logic [1:0] src_side(input logic [1:0] dst, input logic [1:0] rot);
    return dst + 2'd1 + rot;
  endfunction
endpackage

// File: rtl/swb_phase_ctr.sv
module swb_phase_ctr #(
  parameter int MAX_PHASES = 16,
  parameter int PW = (MAX_PHASES > 1) ? $clog2(MAX_PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [PW-1:0] ii_last,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PHASES - 1);

  logic [PW-1:0] last_q;
  logic [PW-1:0] phase_q;

  // Schedule length is captured only inside the reset window.
  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= (ii_last > LIMIT) ? LIMIT : ii_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (!stall) phase_q <= (phase_q >= last_q) ? '0 : phase_q + 1'b1;
  end

  assign phase = phase_q;

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && phase_q == last_q) |=> (phase_q == '0));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && phase_q != last_q) |=> (phase_q == $past(phase_q) + 1'b1));
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= last_q);
  a_r5_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(phase_q));
  a_r8_last_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(last_q));
endmodule

// File: rtl/swb_cfg_mem.sv
module swb_cfg_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int EW    = 12
) (
  input  logic          clk,
  input  logic          load_en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (load_en && we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/swb_out_lane.sv
module swb_out_lane
  import swb_pkg::*;
#(
  parameter int         W   = 16,
  parameter logic [1:0] DST = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  route_t            route,
  input  logic [NDIR*W-1:0] bus_in,
  output logic [W-1:0]      q
);
  logic [1:0]   src;
  logic         take;
  logic [W-1:0] pick;

  assign src  = src_side(DST, route.rot);
  assign take = route.en && (route.rot != 2'd3);
  assign pick = bus_in[int'(src)*W +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= pick;
  end

  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(q));
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!route.en || route.rot == 2'd3) |=> $stable(q));
endmodule

// File: rtl/tmux_switchbox.sv
module tmux_switchbox
  import swb_pkg::*;
#(
  parameter int W          = 16,
  parameter int MAX_PHASES = 16,
  parameter int PW         = (MAX_PHASES > 1) ? $clog2(MAX_PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  input  logic [PW-1:0]      ii_last,
  input  logic               cfg_we,
  input  logic [PW-1:0]      cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic [NDIR*W-1:0]  bus_in,
  output logic [NDIR*W-1:0]  bus_out,
  output logic [PW-1:0]      cur_phase
);
  logic [PW-1:0]      phase;
  logic [ENTRY_W-1:0] sched_entry;
  logic [ENTRY_W-1:0] live_entry;

  swb_phase_ctr #(.MAX_PHASES(MAX_PHASES), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .stall(stall), .ii_last(ii_last), .phase(phase)
  );

  swb_cfg_mem #(.DEPTH(MAX_PHASES), .AW(PW), .EW(ENTRY_W)) u_cfg (
    .clk(clk), .load_en(!rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .raddr(phase), .rdata(sched_entry)
  );

  // One entry and one decode serve every bit lane of a bus.
  assign live_entry = stall ? HOLD_ENTRY : sched_entry;

  for (genvar g = 0; g < NDIR; g++) begin : g_side
    route_t r;
    assign r = route_t'(live_entry[g*ROUTE_W +: ROUTE_W]);
    swb_out_lane #(.W(W), .DST(2'(g))) u_lane (
      .clk(clk), .rst_n(rst_n), .stall(stall), .route(r),
      .bus_in(bus_in), .q(bus_out[g*W +: W])
    );
  end

  assign cur_phase = phase;
endmodule

// File: tb/tmux_switchbox_tb.sv
module tmux_switchbox_tb_top;
  localparam int W = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic [PW-1:0] ii_last = '0;
  logic          cfg_we = 1'b0;
  logic [PW-1:0] cfg_addr = '0;
  logic [11:0]   cfg_wdata = '0;
  logic [4*W-1:0] bus_in = '0;
  logic [4*W-1:0] bus_out;
  logic [PW-1:0]  cur_phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [11:0]   m_cfg [16];
  logic [W-1:0]  exp_out [4];
  logic [PW-1:0] exp_phase;
  logic [PW-1:0] m_last;

  always #10 clk = ~clk;

  tmux_switchbox dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .ii_last(ii_last),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_in(bus_in), .bus_out(bus_out), .cur_phase(cur_phase)
  );

  function automatic logic [11:0] mk(input logic [2:0] n, input logic [2:0] e,
                                     input logic [2:0] s, input logic [2:0] w);
    return {w, s, e, n};
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int d = 0; d < 4; d++) chk(req, $sformatf("out%0d", d), bus_out[d*W +: W], exp_out[d]);
    chk(req, "phase", W'(cur_phase), W'(exp_phase));
  endtask

  // Hold reset, load entries 0..last, release. Ends at a negedge.
  task automatic load(input logic [PW-1:0] last);
    @(negedge clk);
    rst_n = 1'b0;
    stall = 1'b0;
    ii_last = last;
    for (int a = 0; a <= int'(last); a++) begin
      cfg_we = 1'b1; cfg_addr = PW'(a); cfg_wdata = m_cfg[a];
      @(negedge clk);
    end
    cfg_we = 1'b0;
    @(negedge clk);
    m_last = last;
    for (int d = 0; d < 4; d++) exp_out[d] = '0;
    exp_phase = '0;
    check_all("R1");
    rst_n = 1'b1;
  endtask

  // One clock: drive at negedge, test register timing, model, check.
  task automatic step(input logic stl, input string req);
    logic [4*W-1:0] v;
    cyc++;
    for (int d = 0; d < 4; d++) v[d*W +: W] = W'(16'h1000 * (d + 1)) ^ W'(cyc * 37);
    stall = stl;
    bus_in = v;
    #2;
    for (int d = 0; d < 4; d++) chk("R3", "pre-edge", bus_out[d*W +: W], exp_out[d]);
    @(posedge clk);
    if (!stl) begin
      for (int d = 0; d < 4; d++) begin
        logic [2:0] f;
        f = m_cfg[exp_phase][d*3 +: 3];
        if (f[2] && f[1:0] != 2'd3) exp_out[d] = v[((d + 1 + int'(f[1:0])) % 4)*W +: W];
      end
      exp_phase = (exp_phase == m_last) ? '0 : exp_phase + 1'b1;
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic t_basic_routes;
    m_cfg[0] = mk(3'b100, 3'b100, 3'b100, 3'b100);
    m_cfg[1] = mk(3'b101, 3'b101, 3'b101, 3'b101);
    m_cfg[2] = mk(3'b110, 3'b110, 3'b110, 3'b110);
    m_cfg[3] = mk(3'b101, 3'b110, 3'b100, 3'b110);
    load(4'd3);
    for (int i = 0; i < 12; i++) step(1'b0, "R2");
  endtask

  task automatic t_ii_one;
    m_cfg[0] = mk(3'b110, 3'b100, 3'b101, 3'b100);
    load(4'd0);
    for (int i = 0; i < 5; i++) step(1'b0, "R4");
  endtask

  task automatic t_ii_full;
    for (int a = 0; a < 16; a++)
      m_cfg[a] = mk({1'b1, 2'(a % 3)}, {1'b1, 2'((a + 1) % 3)},
                    {1'b1, 2'((a + 2) % 3)}, {1'b1, 2'(a % 3)});
    load(4'd15);
    for (int i = 0; i < 34; i++) step(1'b0, "R4");
  endtask

  task automatic t_stall_resume;
    m_cfg[0] = mk(3'b100, 3'b101, 3'b110, 3'b100);
    m_cfg[1] = mk(3'b110, 3'b100, 3'b101, 3'b110);
    m_cfg[2] = mk(3'b101, 3'b110, 3'b100, 3'b101);
    load(4'd2);
    step(1'b0, "R4");
    step(1'b0, "R4");
    for (int i = 0; i < 4; i++) step(1'b1, "R5");
    for (int i = 0; i < 4; i++) step(1'b0, "R6");
    step(1'b1, "R5");
    step(1'b0, "R6");
  endtask

  task automatic t_disabled;
    m_cfg[0] = mk(3'b100, 3'b101, 3'b110, 3'b100);
    m_cfg[1] = mk(3'b000, 3'b011, 3'b111, 3'b010);
    load(4'd1);
    for (int i = 0; i < 6; i++) step(1'b0, "R7");
  endtask

  task automatic t_load_outside_reset;
    m_cfg[0] = mk(3'b100, 3'b100, 3'b100, 3'b100);
    m_cfg[1] = mk(3'b101, 3'b110, 3'b101, 3'b110);
    m_cfg[2] = mk(3'b110, 3'b101, 3'b110, 3'b101);
    load(4'd2);
    cfg_we = 1'b1;
    cfg_addr = '0;
    cfg_wdata = 12'h000;
    ii_last = 4'd7;
    for (int i = 0; i < 4; i++) step(1'b0, "R8");
    cfg_addr = 4'd1;
    for (int i = 0; i < 5; i++) step(1'b0, "R8");
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_basic_routes();
    t_ii_one();
    t_ii_full();
    t_stall_resume();
    t_disabled();
    t_load_outside_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule